// File: doc/BRIEF.md
# Sequencer Arithmetic Operand Fetch and Execute Unit

This unit carries out the arithmetic instructions of a byte-coded instrument sequencer. On a start pulse it reads an instruction one byte at a time through an offset port, beginning with a one-byte opcode. Flag bits in that opcode decide, for each operand, whether the operand is a one-byte register number or a two-byte literal. Source operands that name registers are read from an external 16-bit register file. The result is written back to the destination register, which is always named by a register number.

The supported operations are add, subtract, multiply, unsigned divide, increment and decrement. A multiply also writes the upper half of its full product into one fixed register. When the instruction is finished the unit pulses `done` and presents the number of bytes it consumed, so the surrounding sequencer can advance its program counter by that amount. An opcode that is not one of the eighteen arithmetic codes ends the instruction with an `illegal` pulse and nothing is written.

Top module: `seq_arith_unit`

## Requirements
- R1: Opcode bit 3 gives the type of operand 1, bit 2 the type of operand 2 and bit 1 the type of operand 3. A 0 means a register operand, which is one byte holding the register number. A 1 means a literal, which is two bytes with the high byte first.
- R2: Opcodes 0x01, 0x03, 0x05 and 0x07 write operand2 + operand3, modulo 2^16, into the register named by operand 1.
- R3: Opcodes 0x11, 0x13, 0x15 and 0x17 write operand2 − operand3, modulo 2^16.
- R4: Opcodes 0x21, 0x23, 0x25 and 0x27 write the low 16 bits of the unsigned product to the destination. On the next cycle they write the high 16 bits to register 199, so register 199 holds the high half even when it is also the destination. No other opcode writes register 199 unless it is the destination.
- R5: Opcodes 0x31, 0x33, 0x35 and 0x37 write the unsigned quotient operand2 / operand3. When the divisor is zero they write 0xFFFF instead, and `div_err` is high during the single cycle in which `done` is high.
- R6: Opcode 0xC6 adds one to the register named by its single register operand, and opcode 0xD0 subtracts one from it. Both wrap modulo 2^16, and both instructions are two bytes long.
- R7: Each legal instruction ends with `done` high for exactly one cycle. While `done` is high, `byte_count` equals 1 plus the operand lengths: 4 for register/register/register, 5 when one source is a literal, 6 when both sources are literals, and 2 for increment and decrement.
- R8: Any other opcode byte, including codes with bit 3 set or bit 0 clear in the arithmetic range, raises `illegal` for one cycle. In that case `done` stays low and no register-file write occurs.
- R9: All source registers are read before the destination is written, so the destination may be the same register as a source.
- R10: After reset, `done`, `illegal`, `div_err` and `rf_we` are low until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one instruction; only seen while idle |
| fetch_off | output | 3 | Byte offset within the instruction being read |
| fetch_byte | input | 8 | Instruction byte at `fetch_off`, same cycle |
| rf_raddr | output | 8 | Register-file read index |
| rf_rdata | input | 16 | Register-file read data, same cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 8 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle unknown-opcode pulse |
| div_err | output | 1 | Divide by zero, coincident with `done` |
| byte_count | output | 3 | Instruction length, valid with `done` |

## Verification
The hardest case to reach from the ports is the ordering of the two multiply writes. It only shows when the destination register is register 199 itself, or when a source register is also the destination, because only then does the order of the writes change a register the bench can read back. The bench therefore adds directed multiply instructions that name register 199 as the destination, and add instructions whose destination also serves as both sources. These come on top of a sweep over every operation, every operand form and a set of boundary values: all ones, zero divisors and sign-bit patterns.

// File: rtl/seq_arith_unit.sv
module seq_arith_unit #(
  parameter int DW     = 16,
  parameter int AW     = 8,
  parameter int HI_REG = 199
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [2:0]    fetch_off,
  input  logic [7:0]    fetch_byte,
  output logic [AW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [AW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          done,
  output logic          illegal,
  output logic          div_err,
  output logic [2:0]    byte_count
);

  localparam logic [AW-1:0] HI_IDX = AW'(HI_REG);
  localparam logic [7:0]    OP_INC = 8'hC6;
  localparam logic [7:0]    OP_DEC = 8'hD0;

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_FETCH, S_READ, S_EXEC, S_HIGH} st_t;

  st_t             state;
  logic [7:0]      opc, hib;
  logic [2:0]      off;
  logic [1:0]      k;
  logic            half;
  logic [AW-1:0]   dst_idx, cur_idx;
  logic [DW-1:0]   v1, v2, v3;
  logic [DW-1:0]   result;
  logic [2*DW-1:0] prod;

  function automatic logic legal_op(input logic [7:0] b);
    return (b[7:4] <= 4'd3 && b[0] && !b[3]) || b == OP_INC || b == OP_DEC;
  endfunction

  wire       unary  = (opc == OP_INC) || (opc == OP_DEC);
  wire [1:0] nops   = unary ? 2'd1 : 2'd3;
  wire       is_mul = (opc[7:4] == 4'd2) && !unary;
  wire       is_div = (opc[7:4] == 4'd3) && !unary;
  wire       imm_k  = (k == 2'd1) ? opc[3] : (k == 2'd2) ? opc[2] : opc[1];
  wire       last_k = (k == nops);

  assign prod       = {{DW{1'b0}}, v2} * {{DW{1'b0}}, v3};
  assign fetch_off  = off;
  assign byte_count = off;
  assign rf_raddr   = cur_idx;
  assign rf_we      = (state == S_EXEC) || (state == S_HIGH);
  assign rf_waddr   = (state == S_HIGH) ? HI_IDX : dst_idx;
  assign rf_wdata   = (state == S_HIGH) ? prod[2*DW-1:DW] : result;

  always_comb begin
    case (opc[7:4])
      4'h0:    result = v2 + v3;
      4'h1:    result = v2 - v3;
      4'h2:    result = prod[DW-1:0];
      4'h3:    result = (v3 == '0) ? '1 : v2 / v3;
      4'hC:    result = v1 + DW'(1);
      default: result = v1 - DW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      opc     <= '0;
      hib     <= '0;
      off     <= '0;
      k       <= '0;
      half    <= 1'b0;
      dst_idx <= '0;
      cur_idx <= '0;
      v1      <= '0;
      v2      <= '0;
      v3      <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
      div_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      div_err <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          off   <= '0;
          state <= S_OPC;
        end
        S_OPC: begin
          opc  <= fetch_byte;
          off  <= 3'd1;
          k    <= 2'd1;
          half <= 1'b0;
          if (legal_op(fetch_byte)) state <= S_FETCH;
          else begin
            illegal <= 1'b1;
            state   <= S_IDLE;
          end
        end
        S_FETCH: begin
          off <= off + 3'd1;
          if (imm_k && !half) begin
            hib  <= fetch_byte;
            half <= 1'b1;
          end else if (imm_k) begin
            half <= 1'b0;
            case (k)
              2'd1:    v1 <= DW'({hib, fetch_byte});
              2'd2:    v2 <= DW'({hib, fetch_byte});
              default: v3 <= DW'({hib, fetch_byte});
            endcase
            if (last_k) state <= S_EXEC;
            else k <= k + 2'd1;
          end else begin
            cur_idx <= AW'(fetch_byte);
            if (k == 2'd1) dst_idx <= AW'(fetch_byte);
            state <= S_READ;
          end
        end
        S_READ: begin
          case (k)
            2'd1:    v1 <= rf_rdata;
            2'd2:    v2 <= rf_rdata;
            default: v3 <= rf_rdata;
          endcase
          if (last_k) state <= S_EXEC;
          else begin
            k     <= k + 2'd1;
            state <= S_FETCH;
          end
        end
        S_EXEC: begin
          if (is_mul) state <= S_HIGH;
          else begin
            done    <= 1'b1;
            div_err <= is_div && (v3 == '0);
            state   <= S_IDLE;
          end
        end
        default: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  // R7
  done_illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && illegal));

  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (byte_count == 3'd2 || byte_count == 3'd4 || byte_count == 3'd5 || byte_count == 3'd6));

  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rf_we));

  // R5
  div_err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> done);

  // R8
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rf_we && !$past(rf_we)));

  // R4
  hi_write_follows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && $past(rf_we)) |-> (rf_waddr == HI_IDX));

endmodule

// File: tb/seq_arith_unit_test.sv
`timescale 1ns/1ps
module seq_arith_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  fetch_off;
  logic [7:0]  fetch_byte;
  logic [7:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we, done, illegal, div_err;
  logic [2:0]  byte_count;

  logic [15:0] regs [256];
  logic [7:0]  prog [8];
  int total = 0, bad = 0, nwrites = 0, cycles = 0;

  always #4 clk = ~clk;

  assign fetch_byte = prog[fetch_off];
  assign rf_rdata   = regs[rf_raddr];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rf_we) begin
      regs[rf_waddr] <= rf_wdata;
      nwrites <= nwrites + 1;
    end
  end

  seq_arith_unit uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic r_done, r_ill, r_dz, r_pulse;
  int   r_cnt, r_nw;

  task automatic run();
    int nw0;
    r_done = 0; r_ill = 0; r_dz = 0; r_cnt = 0; r_pulse = 1;
    @(negedge clk);
    nw0 = nwrites;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done || illegal) begin
        r_done = done; r_ill = illegal; r_dz = div_err; r_cnt = int'(byte_count);
        @(negedge clk);
        r_pulse = !done && !illegal && !div_err;
        break;
      end
    end
    r_nw = nwrites - nw0;
  endtask

  function automatic int put_opnd(input int pos, input bit imm, input logic [15:0] v, input logic [7:0] r);
    if (imm) begin
      prog[pos] = v[15:8];
      prog[pos+1] = v[7:0];
      return pos + 2;
    end
    regs[r] = v;
    prog[pos] = r;
    return pos + 1;
  endfunction

  task automatic arith(input int base, input int form, input logic [15:0] a, input logic [15:0] b);
    logic [7:0]  op;
    logic [31:0] p;
    logic [15:0] exp;
    int pos;
    op = 8'((base << 4) | (form << 1) | 1);
    regs[199] = 16'h5A5A;
    regs[10] = 16'h0;
    prog[0] = op; prog[1] = 8'd10;
    pos = put_opnd(2, op[2], a, 8'd20);
    pos = put_opnd(pos, op[1], b, 8'd21);
    p = {16'h0, a} * {16'h0, b};
    case (base)
      0: exp = a + b;
      1: exp = a - b;
      2: exp = p[15:0];
      default: exp = (b == 0) ? 16'hFFFF : a / b;
    endcase
    run();
    case (base)
      0: chk("R2 add result", {16'h0, regs[10]}, {16'h0, exp});
      1: chk("R3 sub result", {16'h0, regs[10]}, {16'h0, exp});
      2: chk("R4 mul low", {16'h0, regs[10]}, {16'h0, exp});
      default: chk("R5 div result", {16'h0, regs[10]}, {16'h0, exp});
    endcase
    chk("R4 reg199 high or untouched", {16'h0, regs[199]}, {16'h0, (base == 2) ? p[31:16] : 16'h5A5A});
    chk("R1 R7 byte count", r_cnt, pos);
    chk("R7 done one cycle", {r_done, r_pulse, r_ill}, 3'b110);
    chk("R5 div_err", r_dz, (base == 3 && b == 0));
    chk("R4 write count", r_nw, (base == 2) ? 2 : 1);
  endtask

  logic [15:0] pa [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h1234, 16'hABCD, 16'h7FFF, 16'h0100};
  logic [15:0] pb [8] = '{16'h0000, 16'hFFFF, 16'hFFFF, 16'h0002, 16'h0000, 16'h0003, 16'h0001, 16'h0100};

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 16'(i * 3);
    for (int i = 0; i < 8; i++) prog[i] = 8'h0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", {done, illegal, div_err, rf_we}, 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 idle outputs", {done, illegal, div_err, rf_we}, 4'b0000);

    for (int base = 0; base < 4; base++)
      for (int form = 0; form < 4; form++)
        for (int v = 0; v < 8; v++)
          arith(base, form, pa[v], pb[v]);

    // R4 destination is register 199: high half wins
    prog[0] = 8'h21; prog[1] = 8'd199; prog[2] = 8'd40; prog[3] = 8'd41;
    regs[40] = 16'h1234; regs[41] = 16'h5678;
    run();
    chk("R4 dest 199 holds high half", {16'h0, regs[199]}, 32'h0000_0626);

    // R9 destination equals both sources
    prog[0] = 8'h01; prog[1] = 8'd50; prog[2] = 8'd50; prog[3] = 8'd50;
    regs[50] = 16'h8003;
    run();
    chk("R9 aliased add", {16'h0, regs[50]}, 32'h0000_0006);

    // R9 subtract with destination equal to second source
    prog[0] = 8'h13; prog[1] = 8'd51; prog[2] = 8'd51; prog[3] = 8'h00; prog[4] = 8'h05;
    regs[51] = 16'h0003;
    run();
    chk("R9 aliased sub", {16'h0, regs[51]}, 32'h0000_FFFE);

    // R6 increment / decrement with wrap
    prog[0] = 8'hC6; prog[1] = 8'd30; regs[30] = 16'hFFFF;
    run();
    chk("R6 inc wrap", {16'h0, regs[30]}, 32'h0);
    chk("R6 R7 inc count", r_cnt, 2);
    prog[0] = 8'hD0; prog[1] = 8'd31; regs[31] = 16'h0000;
    run();
    chk("R6 dec wrap", {16'h0, regs[31]}, 32'h0000_FFFF);
    chk("R6 R7 dec done", {r_done, r_pulse, r_ill}, 3'b110);
    prog[0] = 8'hC6; prog[1] = 8'd32; regs[32] = 16'h00FF;
    run();
    chk("R6 inc plain", {16'h0, regs[32]}, 32'h0000_0100);

    // R8 every illegal opcode
    for (int op = 0; op < 256; op++) begin
      logic [7:0] b;
      b = 8'(op);
      if ((b[7:4] <= 4'd3 && b[0] && !b[3]) || b == 8'hC6 || b == 8'hD0) continue;
      prog[0] = b; prog[1] = 8'd60; prog[2] = 8'd61; prog[3] = 8'd62;
      run();
      chk("R8 illegal pulse, no done", {r_ill, r_done, r_pulse}, 3'b101);
      chk("R8 no register write", r_nw, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule